// File: doc/BRIEF.md
# Banked Indirect Test-Register Access Unit

This unit sits behind a 16-bit management register bus and lets a host reach banks of internal registers that are otherwise hidden. Three bus addresses are involved. A control word carries a read strobe, a write strobe, a bank number, a test-mode flag and two separate 5-bit word indices, one for reading and one for writing. A read-result register returns the fetched word, and a staging register holds the word to be committed.

The banks stay shut until the host writes four control words in a row: zero, test mode alone, zero, test mode alone. Once the banks are open, a control write with test mode set and a strobe moves one word between the chosen bank and the data registers. A control write with test mode clear shuts the banks again. The analog/DSP bank, the wake bank and the self-test bank hold real storage. The wake bank carries a polled flag at index 0xC bit 12, and the self-test bank holds PLL control and divider words at indices 0x1B to 0x1D. Bank 2 has no storage.

Top module: `tbank_access_top`

## Requirements
- R1: After reset every bank word, the control register, the staging register and the read-result register are zero, and reads of addresses 20, 21 and 23 return zero.
- R2: Address 20 reads back the last control word written. Address 21 returns the read-result register and address 23 returns the staged write word. Every other address reads zero, and writes to other addresses change nothing.
- R3: The banks open after four consecutive control writes (address 20) of 16'h0000, 16'h0400, 16'h0000, 16'h0400. Writes to other addresses between these steps do not disturb the sequence.
- R4: A control write that departs from the sequence restarts it. A departing value of 16'h0000 counts as the first step. A strobe given while the banks are shut changes neither bank contents nor the read-result register.
- R5: While open, a control write with bit 10 clear shuts the banks, and later strobes are ignored until the sequence is repeated.
- R6: While open, a control write with bit 15 set, bit 10 set, bank in bits 12:11 and index in bits 9:5 loads that bank word into the read-result register. The word is visible at address 21 from the next cycle on.
- R7: While open, a control write with bit 14 set, bit 10 set, bank in bits 12:11 and index in bits 4:0 stores the staged word (address 23) into that bank word.
- R8: When bits 15 and 14 are both set, the read is performed and no bank word is written.
- R9: Bank 2 and indices 30 and 31 of every bank read as zero, and writes to them are discarded.
- R10: The read-result register keeps its value until the next accepted read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mgmt_we | input | 1 | Register-bus write enable for one cycle |
| mgmt_addr | input | 5 | Register-bus address for reads and writes |
| mgmt_wdata | input | 16 | Register-bus write data |
| mgmt_rdata | output | 16 | Register-bus read data for mgmt_addr, combinational |

## Verification
A single control write can carry both strobes, so a bank read and a bank write fall in the same cycle. The same holds when the write index and the read index name the same word. The bench provokes this by staging a fresh word and then issuing a control word with both strobes aimed at one index. It judges the result from two values: the read-result register must show the old word, and a later plain read of that index must still return the old word. A second collision is a strobe arriving on the same write that completes or breaks the unlock sequence. The bench checks that such a strobe is ignored.

// File: rtl/tbank_pkg.sv
package tbank_pkg;
  localparam int CW       = 16;
  localparam int BIT_RD   = 15;
  localparam int BIT_WR   = 14;
  localparam int BANK_HI  = 12;
  localparam int BANK_LO  = 11;
  localparam int BIT_TM   = 10;
  localparam int RIDX_HI  = 9;
  localparam int RIDX_LO  = 5;
  localparam int WIDX_HI  = 4;
  localparam int WIDX_LO  = 0;
  localparam int BSEL_W   = BANK_HI - BANK_LO + 1;
  localparam int IDX_W    = RIDX_HI - RIDX_LO + 1;
  localparam int N_BANKS  = 1 << BSEL_W;

  localparam logic [4:0] A_CTRL  = 5'd20;
  localparam logic [4:0] A_RDATA = 5'd21;
  localparam logic [4:0] A_WDATA = 5'd23;

  localparam logic [CW-1:0] TM_ONLY = CW'(1) << BIT_TM;

  typedef enum logic [2:0] {
    UL_IDLE = 3'd0,
    UL_Z1   = 3'd1,
    UL_T1   = 3'd2,
    UL_Z2   = 3'd3,
    UL_OPEN = 3'd4
  } unlock_e;
endpackage

// File: rtl/tbank_unlock.sv
module tbank_unlock
  import tbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic [CW-1:0] ctrl_word,
  output logic          bank_open
);
  unlock_e state_q, state_d;
  logic    is_zero, is_tm;

  assign is_zero = (ctrl_word == '0);
  assign is_tm   = (ctrl_word == TM_ONLY);

  always_comb begin
    state_d = state_q;
    if (ctrl_we) begin
      case (state_q)
        UL_IDLE: state_d = is_zero ? UL_Z1 : UL_IDLE;
        UL_Z1:   state_d = is_tm ? UL_T1 : (is_zero ? UL_Z1 : UL_IDLE);
        UL_T1:   state_d = is_zero ? UL_Z2 : UL_IDLE;
        UL_Z2:   state_d = is_tm ? UL_OPEN : (is_zero ? UL_Z1 : UL_IDLE);
        UL_OPEN: state_d = ctrl_word[BIT_TM] ? UL_OPEN : (is_zero ? UL_Z1 : UL_IDLE);
        default: state_d = UL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= UL_IDLE;
    else        state_q <= state_d;
  end

  assign bank_open = (state_q == UL_OPEN);

  // R3: opening only ever follows the last step of the sequence
  p_open_after_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bank_open) |-> $past(state_q == UL_Z2));

  // R5: a control word without test mode always leaves the banks shut
  p_close_on_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !ctrl_word[BIT_TM]) |=> !bank_open);
endmodule

// File: rtl/tbank_regfile.sv
module tbank_regfile #(
  parameter int DW    = 16,
  parameter int AW    = 5,
  parameter int DEPTH = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam logic [AW:0] LIM = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic          w_in, r_in;

  assign w_in = ({1'b0, waddr} < LIM);
  assign r_in = ({1'b0, raddr} < LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && w_in) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = r_in ? mem[raddr] : '0;

  // R7: an in-range write lands at the addressed word
  p_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && w_in) |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/tbank_access_top.sv
module tbank_access_top
  import tbank_pkg::*;
#(
  parameter int                 BANK_DEPTH   = 30,
  parameter logic [N_BANKS-1:0] BANK_PRESENT = 4'b1011
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mgmt_we,
  input  logic [4:0]    mgmt_addr,
  input  logic [CW-1:0] mgmt_wdata,
  output logic [CW-1:0] mgmt_rdata
);
  logic [1:0]          rst_sync_q;
  logic                rst_n_i;
  logic                ctrl_we, stage_we, bank_open, access_ok, rd_fire, wr_fire;
  logic [BSEL_W-1:0]   sel_bank;
  logic [IDX_W-1:0]    ridx, widx;
  logic [N_BANKS-1:0]  bank_we;
  logic [CW-1:0]       bank_rd [N_BANKS];
  logic [CW-1:0]       ctrl_q, ctrl_d, stage_q, stage_d, rdata_q, rdata_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  assign ctrl_we   = mgmt_we && (mgmt_addr == A_CTRL);
  assign stage_we  = mgmt_we && (mgmt_addr == A_WDATA);
  assign sel_bank  = mgmt_wdata[BANK_HI:BANK_LO];
  assign ridx      = mgmt_wdata[RIDX_HI:RIDX_LO];
  assign widx      = mgmt_wdata[WIDX_HI:WIDX_LO];
  assign access_ok = ctrl_we && bank_open && mgmt_wdata[BIT_TM];
  assign rd_fire   = access_ok && mgmt_wdata[BIT_RD];
  assign wr_fire   = access_ok && mgmt_wdata[BIT_WR] && !mgmt_wdata[BIT_RD];

  tbank_unlock u_unlock (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .ctrl_we   (ctrl_we),
    .ctrl_word (mgmt_wdata),
    .bank_open (bank_open)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    assign bank_we[b] = wr_fire && (sel_bank == BSEL_W'(b));
    if (BANK_PRESENT[b]) begin : g_real
      tbank_regfile #(.DW(CW), .AW(IDX_W), .DEPTH(BANK_DEPTH)) u_rf (
        .clk   (clk),
        .rst_n (rst_n_i),
        .we    (bank_we[b]),
        .waddr (widx),
        .wdata (stage_q),
        .raddr (ridx),
        .rdata (bank_rd[b])
      );
    end else begin : g_void
      assign bank_rd[b] = '0;
    end
  end

  always_comb begin
    ctrl_d  = ctrl_we  ? mgmt_wdata      : ctrl_q;
    stage_d = stage_we ? mgmt_wdata      : stage_q;
    rdata_d = rd_fire  ? bank_rd[sel_bank] : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ctrl_q  <= '0;
      stage_q <= '0;
      rdata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      stage_q <= stage_d;
      rdata_q <= rdata_d;
    end
  end

  always_comb begin
    case (mgmt_addr)
      A_CTRL:  mgmt_rdata = ctrl_q;
      A_RDATA: mgmt_rdata = rdata_q;
      A_WDATA: mgmt_rdata = stage_q;
      default: mgmt_rdata = '0;
    endcase
  end

  // R4: no bank word is written while the banks are shut
  p_locked_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    !bank_open |-> (bank_we == '0));

  // R8: a control word with both strobes never writes
  p_read_wins_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (ctrl_we && mgmt_wdata[BIT_RD] && mgmt_wdata[BIT_WR]) |-> (bank_we == '0));

  // R7: at most one bank takes a write per cycle
  p_we_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    $onehot0(bank_we));

  // R9: reading the bank without storage yields zero
  p_void_bank_zero_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rd_fire && !BANK_PRESENT[sel_bank]) |=> (rdata_q == '0));

  // R10: read result holds unless a read is accepted
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    !rd_fire |=> $stable(rdata_q));
endmodule

// File: tb/tbank_access_top_tb_top.sv
module tbank_access_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mgmt_we;
  logic [4:0]  mgmt_addr;
  logic [15:0] mgmt_wdata;
  logic [15:0] mgmt_rdata;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  localparam logic [15:0] TM = 16'h0400;
  localparam logic [15:0] RD = 16'h8000;
  localparam logic [15:0] WR = 16'h4000;

  always #2 clk = ~clk;

  tbank_access_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mgmt_we    (mgmt_we),
    .mgmt_addr  (mgmt_addr),
    .mgmt_wdata (mgmt_wdata),
    .mgmt_rdata (mgmt_rdata)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic mwrite(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    mgmt_we = 1'b1; mgmt_addr = a; mgmt_wdata = d;
    @(negedge clk);
    mgmt_we = 1'b0;
  endtask

  task automatic mread(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    mgmt_addr = a;
    #1 d = mgmt_rdata;
  endtask

  task automatic unlock();
    mwrite(20, 16'h0000); mwrite(20, TM); mwrite(20, 16'h0000); mwrite(20, TM);
  endtask

  task automatic bread(input int b, input int a, output logic [15:0] d);
    mwrite(20, RD | TM | (16'(b) << 11) | (16'(a) << 5));
    mread(21, d);
  endtask

  task automatic bwrite(input int b, input int a, input logic [15:0] v);
    mwrite(23, v);
    mwrite(20, WR | TM | (16'(b) << 11) | 16'(a));
  endtask

  function automatic logic [15:0] pat(input int b, input int a);
    return (16'(b) * 16'h1111) ^ (16'(a) * 16'h0203) ^ 16'hA5C3;
  endfunction

  function automatic logic [15:0] expv(input int b, input int a);
    return (b == 2 || a >= 30) ? 16'h0000 : pat(b, a);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, hold;
    rst_n = 1'b0; mgmt_we = 1'b0; mgmt_addr = '0; mgmt_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    mread(20, v); chk("R1 ctrl", v, 16'h0);
    mread(21, v); chk("R1 rdata", v, 16'h0);
    mread(23, v); chk("R1 stage", v, 16'h0);
    unlock();
    for (int b = 0; b < 4; b++)
      for (int a = 0; a < 32; a += 7) begin
        bread(b, a, v); chk($sformatf("R1 bank%0d[%0d]", b, a), v, 16'h0);
      end

    // R2 address map
    mwrite(22, 16'hBEEF); mread(22, v); chk("R2 other addr", v, 16'h0);
    mwrite(23, 16'h1357); mread(23, v); chk("R2 stage readback", v, 16'h1357);
    mread(20, v); chk("R2 ctrl readback", v, TM | 16'h8000 | (16'd3 << 11) | (16'd28 << 5));

    // R6 R7 R9 sweep
    for (int b = 0; b < 4; b++)
      for (int a = 0; a < 32; a++) bwrite(b, a, pat(b, a));
    for (int b = 0; b < 4; b++)
      for (int a = 0; a < 32; a++) begin
        bread(b, a, v); chk($sformatf("R6/R7/R9 bank%0d[%0d]", b, a), v, expv(b, a));
      end

    // R7 named words
    bwrite(1, 12, 16'h1000); bread(1, 12, v); chk("R7 wake flag", v & 16'h1000, 16'h1000);
    bwrite(3, 27, 16'h0005); bwrite(3, 29, 16'h029A); bwrite(3, 28, 16'hAAAA);
    bread(3, 27, v); chk("R7 pll ctl", v, 16'h0005);
    bread(3, 29, v); chk("R7 div1", v, 16'h029A);
    bread(3, 28, v); chk("R7 div0", v, 16'hAAAA);

    // R8 both strobes: read old, no write
    mwrite(23, 16'h7777);
    mwrite(20, RD | WR | TM | (16'd4 << 5) | 16'd4);
    mread(21, v); chk("R8 read result", v, pat(0, 4));
    bread(0, 4, v); chk("R8 no write", v, pat(0, 4));

    // R10 hold across non-read control writes
    bread(0, 6, hold);
    bwrite(0, 7, 16'h4242);
    mwrite(20, TM);
    mread(21, v); chk("R10 hold", v, hold);

    // R5 close with nonzero word lacking test mode
    mwrite(20, 16'h0001);
    bwrite(0, 8, 16'h9999);
    mwrite(20, RD | TM | (16'd9 << 5));
    mread(21, v); chk("R5 read ignored", v, hold);
    unlock(); bread(0, 8, v); chk("R5 write ignored", v, pat(0, 8));

    // R4 broken sequences and strobe on final step
    mwrite(20, 16'h0000);
    mwrite(20, 16'h0000); mwrite(20, TM); mwrite(20, 16'h0005); mwrite(20, TM);
    bwrite(0, 9, 16'h3131);
    mwrite(20, 16'h0000); mwrite(20, TM); mwrite(20, 16'h0000);
    mwrite(20, TM | WR | 16'd10);
    bwrite(0, 10, 16'h2222);
    unlock();
    bread(0, 9, v); chk("R4 broken seq", v, pat(0, 9));
    bread(0, 10, v); chk("R4 strobe on step", v, pat(0, 10));
    // departing zero counts as first step
    mwrite(20, 16'h0000); mwrite(20, TM); mwrite(20, 16'h0000); mwrite(20, 16'h0000);
    mwrite(20, TM); mwrite(20, 16'h0000); mwrite(20, TM);
    bread(0, 11, v); chk("R4 zero restart", v, pat(0, 11));

    // R3 interleaved writes to other addresses
    mwrite(20, 16'h0000); mwrite(23, 16'h6161); mwrite(20, TM); mwrite(22, 16'h1);
    mwrite(20, 16'h0000); mwrite(20, TM);
    mwrite(20, WR | TM | 16'd13);
    bread(0, 13, v); chk("R3 open with interleave", v, 16'h6161);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule